// File: doc/BRIEF.md
# Pipelined Rotation-Mode CORDIC Sine/Cosine Generator

This block turns an angle into its cosine and sine using only adders and fixed wiring. It is a chain of identical micro-rotation stages, one per pipeline register. Each stage turns a two-component vector by a known small angle, either forward or backward. The direction comes from the sign of the angle that is still left to rotate.

The starting vector is pre-shrunk by the reciprocal of the chain's total gain, so no multiplier is needed at the output. A fresh angle can be presented on every clock. Each result leaves the block a fixed number of cycles later, together with a delayed copy of the input's valid flag.

The block is meant to sit behind a phase source that has already folded the angle into the right half-plane. Quadrant reconstruction belongs to the surrounding logic.

Angles use a binary-turn format: the input is read as two's complement, and 2^ANGLE_W units make one full turn. Outputs are two's complement, and full scale (±1.0) maps to ±(2^(OUT_W-1)-1). Inside the chain, x and y carry GUARD extra fraction bits and one headroom bit. They are rounded and clamped in a final output register.

Top module: `cordic_rotator`

## Requirements
- R1: A synchronous active-low reset clears out_valid, out_cos and out_sin to zero in the cycle after it is sampled. It also flushes every angle still in flight, so no out_valid pulse appears for inputs accepted before the reset.
- R2: out_valid equals in_valid from exactly STAGES+1 clock cycles earlier: STAGES rotation registers plus one output register.
- R3: The block takes a new angle on every cycle with no stall. The number of valid results equals the number of valid inputs, and back-to-back inputs give back-to-back results.
- R4: For an input angle θ with its two top bits equal (|θ| below a quarter turn), out_cos is within 6 LSB of round(cos(2π·θ/2^ANGLE_W)·(2^(OUT_W-1)-1)). Such a cosine is never below -16.
- R5: Under the same input condition, out_sin is within 6 LSB of round(sin(2π·θ/2^ANGLE_W)·(2^(OUT_W-1)-1)). When its magnitude exceeds 16, its sign bit equals the sign bit of θ.
- R6: Results are clamped to ±(2^(OUT_W-1)-1). The code -2^(OUT_W-1) never appears on out_cos or out_sin while out_valid is high, including at angle zero and at exactly ± a quarter turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_angle as a sample to convert |
| in_angle | input | ANGLE_W | Angle, two's complement, 2^ANGLE_W units per turn |
| out_valid | output | 1 | Marks out_cos/out_sin as a result |
| out_cos | output | OUT_W | Cosine, two's complement, full scale 2^(OUT_W-1)-1 |
| out_sin | output | OUT_W | Sine, two's complement, full scale 2^(OUT_W-1)-1 |

## Verification
The bench builds the block with its defaults: a 32-bit angle, 16-bit outputs, 16 stages and 2 guard bits, which gives a 17-cycle latency. At that size the arctangent steps fall below one output LSB by the last stage. The 6-LSB bound therefore exposes any wrong constant, wrong shift or wrong direction. The exact quarter-turn and zero angles drive the vector to full scale, which exercises the clamp. A reset in mid-stream checks that a deep pipeline full of live samples is flushed.

// File: rtl/cordic_pkg.sv
// Shared constants for the CORDIC rotator.
// Assumes angles in binary-turn units: 2^w units make one full revolution.
package cordic_pkg;

    // atan(2^-idx) expressed in 32-bit binary-turn units (2^32 = one turn)
    function automatic longint atan_turn32(input int idx);
        case (idx)
            0:  return longint'(536870912);
            1:  return longint'(316933406);
            2:  return longint'(167458907);
            3:  return longint'(85004756);
            4:  return longint'(42667331);
            5:  return longint'(21354465);
            6:  return longint'(10679838);
            7:  return longint'(5340245);
            8:  return longint'(2670163);
            9:  return longint'(1335087);
            10: return longint'(667544);
            11: return longint'(333772);
            12: return longint'(166886);
            13: return longint'(83443);
            14: return longint'(41722);
            15: return longint'(20861);
            16: return longint'(10430);
            default: return longint'(10430) >>> (idx - 16);
        endcase
    endfunction

    // Same constant rescaled to an angle word of width aw
    function automatic longint atan_const(input int idx, input int aw);
        longint r;
        r = atan_turn32(idx);
        if (aw <= 32) return r >>> (32 - aw);
        return r <<< (aw - 32);
    endfunction

    // Starting x: full scale times the reciprocal chain gain (0.6072529 in Q30)
    function automatic longint gain_seed(input int ow, input int guard);
        longint fs;
        fs = ((longint'(1) <<< (ow - 1)) - 1) <<< guard;
        return (fs * longint'(652032875) + (longint'(1) <<< 29)) >>> 30;
    endfunction

endpackage

// File: rtl/cordic_stage.sv
// One micro-rotation of the x/y vector by +/- atan(2^-SHIFT).
// Assumes the direction is decided upstream from the residual angle; the shift
// is a constant so the datapath is a single add/subtract per component.
module cordic_stage #(
    parameter int IW    = 19,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic                 dir_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    output logic                 v_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o
);

    logic signed [IW-1:0] x_sh, y_sh, x_nx, y_nx;

    // Cross-coupled add/subtract with hardwired arithmetic shifts
    always_comb begin
        x_sh = x_i >>> SHIFT;
        y_sh = y_i >>> SHIFT;
        if (dir_i) begin
            x_nx = x_i - y_sh;
            y_nx = y_i + x_sh;
        end else begin
            x_nx = x_i + y_sh;
            y_nx = y_i - x_sh;
        end
    end

    // Stage register for vector and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= x_nx;
            y_o <= y_nx;
        end
    end

endmodule

// File: rtl/cordic_angle_step.sv
// Residual-angle update for one stage: removes the angle that stage IDX turned.
// Assumes it is only built for stages whose residual a later stage consumes.
module cordic_angle_step
    import cordic_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_i,
    input  logic signed [AW-1:0] z_i,
    output logic signed [AW-1:0] z_o
);

    localparam logic signed [AW-1:0] STEP = AW'(atan_const(IDX, AW));

    // Subtract or add this stage's arctangent constant
    always_ff @(posedge clk) begin
        if (!rst_n) z_o <= '0;
        else        z_o <= dir_i ? (z_i - STEP) : (z_i + STEP);
    end

endmodule

// File: rtl/cordic_out.sv
// Output register: rounds away the guard bits and clamps to the symmetric range.
// Assumes IW has one headroom bit above OW+GUARD so the rounding add cannot wrap.
module cordic_out #(
    parameter int IW    = 19,
    parameter int OW    = 16,
    parameter int GUARD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    output logic                 v_o,
    output logic [OW-1:0]        c_o,
    output logic [OW-1:0]        s_o
);

    localparam int HALF = (GUARD > 0) ? (1 << ((GUARD > 0) ? GUARD - 1 : 0)) : 0;
    localparam logic signed [IW-1:0] HALF_V = IW'(HALF);
    localparam logic signed [IW-1:0] HI     = IW'((1 << (OW - 1)) - 1);
    localparam logic signed [IW-1:0] LO     = -HI;

    // Round to nearest, then clamp into +/-(2^(OW-1)-1)
    function automatic logic [OW-1:0] shape(input logic signed [IW-1:0] a);
        logic signed [IW-1:0] r;
        r = (a + HALF_V) >>> GUARD;
        if (r > HI)      return OW'(HI);
        else if (r < LO) return OW'(LO);
        return OW'(r);
    endfunction

    logic [OW-1:0] c_nx, s_nx;

    // Shape both components
    always_comb begin
        c_nx = shape(x_i);
        s_nx = shape(y_i);
    end

    // Final result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            c_o <= '0;
            s_o <= '0;
        end else begin
            v_o <= v_i;
            c_o <= c_nx;
            s_o <= s_nx;
        end
    end

endmodule

// File: rtl/cordic_rotator.sv
// Fully pipelined rotation-mode CORDIC: one angle per clock in, cos/sin out
// STAGES+1 cycles later. Assumes the caller keeps |angle| below a quarter turn.
module cordic_rotator
    import cordic_pkg::*;
#(
    parameter int ANGLE_W = 32,
    parameter int OUT_W   = 16,
    parameter int STAGES  = 16,
    parameter int GUARD   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ANGLE_W-1:0] in_angle,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_cos,
    output logic [OUT_W-1:0]   out_sin
);

    localparam int IW = OUT_W + GUARD + 1;
    localparam logic signed [IW-1:0] X_INIT = IW'(gain_seed(OUT_W, GUARD));

    logic signed [IW-1:0]      xs [0:STAGES];
    logic signed [IW-1:0]      ys [0:STAGES];
    logic                      vs [0:STAGES];
    logic signed [ANGLE_W-1:0] zs [0:STAGES-1];
    logic [STAGES-1:0]         dirs;

    // Gain-compensated starting vector on the x axis
    assign xs[0] = X_INIT;
    assign ys[0] = '0;
    assign vs[0] = in_valid;
    assign zs[0] = $signed(in_angle);

    for (genvar i = 0; i < STAGES; i++) begin : g_pipe
        // Rotate forward only while the residual is strictly positive
        assign dirs[i] = !zs[i][ANGLE_W-1] && (zs[i] != '0);

        cordic_stage #(.IW(IW), .SHIFT(i)) u_rot (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (vs[i]),
            .dir_i (dirs[i]),
            .x_i   (xs[i]),
            .y_i   (ys[i]),
            .v_o   (vs[i+1]),
            .x_o   (xs[i+1]),
            .y_o   (ys[i+1])
        );

        if (i < STAGES - 1) begin : g_ang
            cordic_angle_step #(.AW(ANGLE_W), .IDX(i)) u_ang (
                .clk   (clk),
                .rst_n (rst_n),
                .dir_i (dirs[i]),
                .z_i   (zs[i]),
                .z_o   (zs[i+1])
            );
        end
    end

    cordic_out #(.IW(IW), .OW(OUT_W), .GUARD(GUARD)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (vs[STAGES]),
        .x_i   (xs[STAGES]),
        .y_i   (ys[STAGES]),
        .v_o   (out_valid),
        .c_o   (out_cos),
        .s_o   (out_sin)
    );

endmodule

// File: rtl/cordic_rotator_chk.sv
// Property checker for cordic_rotator, bound to every instance.
// Assumes a reset is applied from time zero.
module cordic_rotator_chk #(
    parameter int OW     = 16,
    parameter int STAGES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    ang_top,
    input logic          out_valid,
    input logic [OW-1:0] out_cos,
    input logic [OW-1:0] out_sin
);

    localparam int LAT = STAGES + 1;
    localparam int MAG = 16;

    logic [LAT-1:0] v_line, neg_line, ok_line;
    logic           was_rst = 1'b0;

    // Delay lines for valid, angle sign and in-range flag
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (!rst_n) begin
            v_line   <= '0;
            neg_line <= '0;
            ok_line  <= '0;
        end else begin
            v_line   <= {v_line[LAT-2:0], in_valid};
            neg_line <= {neg_line[LAT-2:0], ang_top[1]};
            ok_line  <= {ok_line[LAT-2:0], ang_top[1] == ang_top[0]};
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!out_valid && out_cos == '0 && out_sin == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_line[LAT-1]);

    // R4
    cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ok_line[LAT-1]) |-> ($signed(out_cos) >= -MAG));

    // R5
    sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ok_line[LAT-1] && ($signed(out_sin) > MAG || $signed(out_sin) < -MAG))
        |-> (out_sin[OW-1] == neg_line[LAT-1]));

    // R6
    no_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cos != {1'b1, {(OW-1){1'b0}}} && out_sin != {1'b1, {(OW-1){1'b0}}}));

endmodule

bind cordic_rotator cordic_rotator_chk #(.OW(OUT_W), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ang_top   (in_angle[ANGLE_W-1:ANGLE_W-2]),
    .out_valid (out_valid),
    .out_cos   (out_cos),
    .out_sin   (out_sin)
);

// File: tb/cordic_rotator_test.sv
`timescale 1ns/1ps
module cordic_rotator_test;

    localparam int AW = 32, OW = 16, ST = 16, LAT = ST + 1, N = 600, TOL = 6;
    localparam real FS = 32767.0;
    localparam real TWO_PI = 6.283185307179586;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_angle = '0;
    logic          out_valid;
    logic [OW-1:0] out_cos, out_sin;

    always #2 clk = ~clk;

    cordic_rotator #(.ANGLE_W(AW), .OUT_W(OW), .STAGES(ST), .GUARD(2)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
        .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin));

    int errs = 0, checks = 0, n_in = 0, n_out = 0;
    bit done = 0;
    logic [AW-1:0] st_a [N];
    logic          st_v [N];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cos(input logic [AW-1:0] a);
        return int'($cos(real'($signed(a)) * TWO_PI / 4294967296.0) * FS);
    endfunction

    function automatic int exp_sin(input logic [AW-1:0] a);
        return int'($sin(real'($signed(a)) * TWO_PI / 4294967296.0) * FS);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errs++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd20250));
        // Directed corners first, as one back-to-back burst (R3)
        st_a[0] = 32'h0000_0000; st_a[1] = 32'h4000_0000; st_a[2] = 32'hC000_0000;
        st_a[3] = 32'h2000_0000; st_a[4] = 32'hE000_0000; st_a[5] = 32'h0000_0001;
        st_a[6] = 32'hFFFF_FFFF; st_a[7] = 32'h3FFF_FFFF; st_a[8] = 32'hC000_0001;
        st_a[9] = 32'h1555_5555; st_a[10] = 32'hEAAA_AAAB; st_a[11] = 32'h0000_8000;
        for (int i = 0; i < 20; i++) st_v[i] = 1'b1;
        for (int i = 12; i < 20; i++) begin
            logic [31:0] r;
            r = $urandom();
            st_a[i] = {r[31], r[31], r[29:0]};
        end
        for (int i = 20; i < N; i++) begin
            logic [31:0] r;
            r = $urandom();
            st_a[i] = {r[31], r[31], r[29:0]};
            st_v[i] = ($urandom() % 4) != 0;
        end

        // Reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(out_cos == '0, "R1", "out_cos in reset", int'(out_cos), 0);
        chk(out_sin == '0, "R1", "out_sin in reset", int'(out_sin), 0);

        rst_n = 1'b1;
        in_valid = st_v[0]; in_angle = st_a[0];
        if (st_v[0]) n_in++;
        for (int n = 1; n <= N + LAT; n++) begin
            int idx;
            bit ev;
            @(negedge clk);
            idx = n - LAT;
            ev = (idx >= 0) ? st_v[idx] : 1'b0;
            chk(out_valid == ev, "R2", "out_valid vs delayed in_valid", int'(out_valid), int'(ev));
            if (out_valid) begin
                n_out++;
                chk(out_cos != 16'h8000 && out_sin != 16'h8000, "R6", "minimum code",
                    $signed(out_cos), -32767);
                if (ev) begin
                    int ec, es, ac, as_;
                    ec = exp_cos(st_a[idx]); es = exp_sin(st_a[idx]);
                    ac = $signed(out_cos);   as_ = $signed(out_sin);
                    chk(iabs(ac - ec) <= TOL, "R4", "cosine", ac, ec);
                    chk(iabs(as_ - es) <= TOL, "R5", "sine", as_, es);
                end
            end
            if (n < N) begin
                in_valid = st_v[n]; in_angle = st_a[n];
                if (st_v[n]) n_in++;
            end else begin
                in_valid = 1'b0; in_angle = '0;
            end
        end
        chk(n_out == n_in, "R3", "result count", n_out, n_in);

        // Mid-stream reset flushes in-flight samples (R1)
        for (int k = 0; k < 8; k++) begin
            in_valid = 1'b1; in_angle = 32'h1000_0000;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_cos == '0 && out_sin == '0, "R1", "after mid-stream reset",
            int'(out_valid), 0);
        rst_n = 1'b1;
        for (int k = 0; k < LAT + 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "flushed pipeline stays quiet", int'(out_valid), 0);
        end
        summary();
    end

endmodule